// File: doc/BRIEF.md
# Registered Two-Port Bus Exchange Unit

This block moves data between two parallel ports, A and B, inside a single clock domain. Each port has a separate input vector, output vector and output-enable, so pad-level tri-stating stays outside the block. One master enable (active low) and one direction input decide which port, if any, is driven. The other port always acts as an input.

There is a storage register for each direction. A capture strobe for each direction loads it. The strobes may arrive asynchronously: each goes through a two-flop synchronizer, and its rising edge becomes a one-cycle load pulse. For each direction, a select input picks what the driven port shows: the other port's input, passed straight through, or the stored copy. Capture never depends on the enable or the direction. A port can therefore be snapshotted while the outputs are isolated, or while the opposite port is being driven.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge on `capAtoB` loads `portAIn` into the A-to-B register. The new value can be seen at the outputs after the third rising `clk` edge that follows the strobe's rise, provided `portAIn` stays steady over those edges.
- R2: A rising edge on `capBtoA` loads `portBIn` into the B-to-A register, with the same three-edge latency.
- R3: Capture works for every value of `enN`, `towardB` and the two selects, including the isolated state.
- R4: While `enN` is 1, both `portAOe` and `portBOe` are 0, and both output vectors are 0.
- R5: While `enN` is 0, `towardB`=0 drives port A only, and `towardB`=1 drives port B only.
- R6: While port A is driven, `selBtoA`=0 makes `portAOut` equal `portBIn` in the same cycle, with no clock edge between them.
- R7: While port A is driven, `selBtoA`=1 makes `portAOut` equal the B-to-A register.
- R8: While port B is driven, `selAtoB`=0 makes `portBOut` equal `portAIn` combinationally, and `selAtoB`=1 makes it equal the A-to-B register.
- R9: `portAOe` and `portBOe` are never 1 at the same time.
- R10: While `rst` is 1, both output-enables are 0. After reset both registers read 0.
- R11: Only a low-to-high strobe transition loads a register. A strobe held high keeps the register at its value even if the input data changes, and so does a strobe held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enN | input | 1 | Master output enable, active low |
| towardB | input | 1 | 0: drive port A, 1: drive port B |
| selAtoB | input | 1 | Port B source: 0 live A, 1 stored A-to-B |
| selBtoA | input | 1 | Port A source: 0 live B, 1 stored B-to-A |
| capAtoB | input | 1 | Capture strobe for the A-to-B register (asynchronous) |
| capBtoA | input | 1 | Capture strobe for the B-to-A register (asynchronous) |
| portAIn | input | WIDTH | Data arriving on port A |
| portAOut | output | WIDTH | Data driven onto port A |
| portAOe | output | 1 | Port A output enable |
| portBIn | input | WIDTH | Data arriving on port B |
| portBOut | output | WIDTH | Data driven onto port B |
| portBOe | output | 1 | Port B output enable |

## Verification
The assertions check on every cycle:
- that the two enables are mutually exclusive;
- that the master enable isolates both ports;
- that the direction decode is correct;
- that the driven port carries the live or the stored value its select asks for;
- that both registers are zero once reset ends.

Only the bench scenarios can show the following:
- the exact three-edge capture latency;
- that a strobe held high does not reload its register;
- that capture works while the outputs are isolated or the opposite port is driven.

These need the stimulus history and a known data value.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef struct packed {
    logic loadAB;
    logic loadBA;
    logic driveA;
    logic driveB;
    logic pickStoredA;
    logic pickStoredB;
  } xferCtl_t;
endpackage

// File: rtl/regbus_xcvr_edge.sv
module regbus_xcvr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobeRaw,
  output logic risePulse
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] syncChain;
  logic prevLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[STAGES-2:0], strobeRaw};
      prevLevel <= syncChain[LAST];
    end
  end

  assign risePulse = syncChain[LAST] & ~prevLevel;
endmodule

// File: rtl/regbus_xcvr_ctrl.sv
module regbus_xcvr_ctrl
  import regbus_xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enN,
  input  logic     towardB,
  input  logic     selAtoB,
  input  logic     selBtoA,
  input  logic     capAtoB,
  input  logic     capBtoA,
  output xferCtl_t ctl
);
  localparam int NUM_DIR = 2;
  logic [NUM_DIR-1:0] rawStrobes;
  logic [NUM_DIR-1:0] loads;

  assign rawStrobes = {capBtoA, capAtoB};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    regbus_xcvr_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst       (rst),
      .strobeRaw (rawStrobes[d]),
      .risePulse (loads[d])
    );
  end

  logic outputsOn;
  assign outputsOn = ~enN & ~rst;

  always_comb begin
    ctl.loadAB      = loads[0];
    ctl.loadBA      = loads[1];
    ctl.driveA      = outputsOn & ~towardB;
    ctl.driveB      = outputsOn & towardB;
    ctl.pickStoredA = selBtoA;
    ctl.pickStoredB = selAtoB;
  end
endmodule

// File: rtl/regbus_xcvr_datapath.sv
module regbus_xcvr_datapath
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xferCtl_t         ctl,
  input  logic [WIDTH-1:0] portAIn,
  input  logic [WIDTH-1:0] portBIn,
  output logic [WIDTH-1:0] portAOut,
  output logic [WIDTH-1:0] portBOut,
  output logic [WIDTH-1:0] storedAB,
  output logic [WIDTH-1:0] storedBA
);
  always_ff @(posedge clk) begin
    if (rst) begin
      storedAB <= '0;
      storedBA <= '0;
    end else begin
      if (ctl.loadAB) storedAB <= portAIn;
      if (ctl.loadBA) storedBA <= portBIn;
    end
  end

  logic [WIDTH-1:0] srcForA, srcForB;
  assign srcForA = ctl.pickStoredA ? storedBA : portBIn;
  assign srcForB = ctl.pickStoredB ? storedAB : portAIn;

  assign portAOut = ctl.driveA ? srcForA : '0;
  assign portBOut = ctl.driveB ? srcForB : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enN,
  input  logic             towardB,
  input  logic             selAtoB,
  input  logic             selBtoA,
  input  logic             capAtoB,
  input  logic             capBtoA,
  input  logic [WIDTH-1:0] portAIn,
  output logic [WIDTH-1:0] portAOut,
  output logic             portAOe,
  input  logic [WIDTH-1:0] portBIn,
  output logic [WIDTH-1:0] portBOut,
  output logic             portBOe
);
  xferCtl_t ctl;
  logic [WIDTH-1:0] storedAB, storedBA;

  regbus_xcvr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enN     (enN),
    .towardB (towardB),
    .selAtoB (selAtoB),
    .selBtoA (selBtoA),
    .capAtoB (capAtoB),
    .capBtoA (capBtoA),
    .ctl     (ctl)
  );

  regbus_xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .portAOut (portAOut),
    .portBOut (portBOut),
    .storedAB (storedAB),
    .storedBA (storedBA)
  );

  assign portAOe = ctl.driveA;
  assign portBOe = ctl.driveB;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enN,
  input logic             towardB,
  input logic             selAtoB,
  input logic             selBtoA,
  input logic [WIDTH-1:0] portAIn,
  input logic [WIDTH-1:0] portBIn,
  input logic [WIDTH-1:0] portAOut,
  input logic [WIDTH-1:0] portBOut,
  input logic             portAOe,
  input logic             portBOe,
  input logic [WIDTH-1:0] storedAB,
  input logic [WIDTH-1:0] storedBA
);
  assert_one_driver_R9: assert property (@(posedge clk) disable iff (rst)
    !(portAOe && portBOe));

  assert_isolate_R4: assert property (@(posedge clk) disable iff (rst)
    enN |-> (!portAOe && !portBOe && portAOut == '0 && portBOut == '0));

  assert_dir_A_R5: assert property (@(posedge clk) disable iff (rst)
    (!enN && !towardB) |-> (portAOe && !portBOe));

  assert_dir_B_R5: assert property (@(posedge clk) disable iff (rst)
    (!enN && towardB) |-> (portBOe && !portAOe));

  assert_live_to_a_R6: assert property (@(posedge clk) disable iff (rst)
    (portAOe && !selBtoA) |-> (portAOut == portBIn));

  assert_stored_to_a_R7: assert property (@(posedge clk) disable iff (rst)
    (portAOe && selBtoA) |-> (portAOut == storedBA));

  assert_path_to_b_R8: assert property (@(posedge clk) disable iff (rst)
    portBOe |-> (portBOut == (selAtoB ? storedAB : portAIn)));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (storedAB == '0 && storedBA == '0));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enN      (enN),
  .towardB  (towardB),
  .selAtoB  (selAtoB),
  .selBtoA  (selBtoA),
  .portAIn  (portAIn),
  .portBIn  (portBIn),
  .portAOut (portAOut),
  .portBOut (portBOut),
  .portAOe  (portAOe),
  .portBOe  (portBOe),
  .storedAB (storedAB),
  .storedBA (storedBA)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, enN, towardB, selAtoB, selBtoA, capAtoB, capBtoA;
  logic [W-1:0] portAIn, portBIn, portAOut, portBOut;
  logic portAOe, portBOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] expAB, expBA;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .enN(enN), .towardB(towardB),
    .selAtoB(selAtoB), .selBtoA(selBtoA),
    .capAtoB(capAtoB), .capBtoA(capBtoA),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expOutA();
    if (rst || enN || towardB) return '0;
    return selBtoA ? expBA : portBIn;
  endfunction

  function automatic logic [W-1:0] expOutB();
    if (rst || enN || !towardB) return '0;
    return selAtoB ? expAB : portAIn;
  endfunction

  // sample away from the rising edge
  task automatic checkPorts(string tag);
    #1;
    checkEq({tag, " oeA"}, 32'(portAOe), 32'(!rst && !enN && !towardB));
    checkEq({tag, " oeB"}, 32'(portBOe), 32'(!rst && !enN && towardB));
    checkEq({tag, " outA"}, 32'(portAOut), 32'(expOutA()));
    checkEq({tag, " outB"}, 32'(portBOut), 32'(expOutB()));
    checkEq({tag, " R9 exclusive"}, 32'(portAOe & portBOe), 32'd0);
  endtask

  // raises the selected strobes, loads land on the third rising edge
  task automatic capture(bit doA, bit doB);
    @(negedge clk);
    capAtoB = doA;
    capBtoA = doB;
    repeat (3) @(posedge clk);
    if (doA) expAB = portAIn;
    if (doB) expBA = portBIn;
    @(negedge clk);
    capAtoB = 1'b0;
    capBtoA = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic showStored(string tag);
    @(negedge clk);
    enN = 1'b0; towardB = 1'b0; selBtoA = 1'b1;
    #1 checkEq({tag, " storedBA"}, 32'(portAOut), 32'(expBA));
    towardB = 1'b1; selAtoB = 1'b1;
    #1 checkEq({tag, " storedAB"}, 32'(portBOut), 32'(expAB));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h1bad5eed);
    rst = 1'b1; enN = 1'b0; towardB = 1'b0; selAtoB = 1'b0; selBtoA = 1'b0;
    capAtoB = 1'b0; capBtoA = 1'b0; portAIn = 8'h3c; portBIn = 8'hc3;
    expAB = '0; expBA = '0;
    repeat (3) @(negedge clk);
    checkPorts("R10 in reset");
    @(negedge clk);
    rst = 1'b0;
    showStored("R10 after reset");

    // R6 R8: live path follows input with no clock
    @(negedge clk);
    enN = 1'b0; towardB = 1'b0; selBtoA = 1'b0; portBIn = 8'h5a;
    #1 checkEq("R6 live B->A", 32'(portAOut), 32'h5a);
    portBIn = 8'ha5;
    #1 checkEq("R6 live B->A immediate", 32'(portAOut), 32'ha5);
    towardB = 1'b1; selAtoB = 1'b0; portAIn = 8'h77;
    #1 checkEq("R8 live A->B", 32'(portBOut), 32'h77);

    // R4 R3: capture both while isolated
    @(negedge clk);
    enN = 1'b1; portAIn = 8'h11; portBIn = 8'h22;
    checkPorts("R4 isolated");
    capture(1'b1, 1'b1);
    checkPorts("R4 isolated after capture");
    showStored("R1 R2 R3 isolated capture");

    // R3: capture port A while port A is the driven one
    @(negedge clk);
    enN = 1'b0; towardB = 1'b0; portAIn = 8'h9e;
    capture(1'b1, 1'b0);
    showStored("R3 capture while A driven");

    // R1 latency: not yet loaded after two edges
    @(negedge clk);
    enN = 1'b0; towardB = 1'b1; selAtoB = 1'b1; portAIn = 8'he4;
    capAtoB = 1'b1;
    repeat (2) @(posedge clk);
    #1 checkEq("R1 no load after two edges", 32'(portBOut), 32'(expAB));
    @(posedge clk);
    expAB = 8'he4;
    #1 checkEq("R1 load on third edge", 32'(portBOut), 32'he4);

    // R11: held-high strobe does not reload
    @(negedge clk);
    portAIn = 8'h0f;
    repeat (5) @(negedge clk);
    #1 checkEq("R11 held high", 32'(portBOut), 32'he4);
    capAtoB = 1'b0;
    repeat (4) @(negedge clk);
    #1 checkEq("R11 held low", 32'(portBOut), 32'he4);

    // R7: stored data to A
    @(negedge clk);
    towardB = 1'b0; selBtoA = 1'b1; portBIn = 8'h66;
    #1 checkEq("R7 stored to A", 32'(portAOut), 32'(expBA));

    // random mix, R1 R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 300; i++) begin
      int pick;
      @(negedge clk);
      enN = 1'($urandom); towardB = 1'($urandom);
      selAtoB = 1'($urandom); selBtoA = 1'($urandom);
      portAIn = W'($urandom); portBIn = W'($urandom);
      pick = int'($urandom % 4);
      if (pick != 0) capture(pick[0], pick[1]);
      @(negedge clk);
      portAIn = W'($urandom); portBIn = W'($urandom);
      checkPorts("R5 R6 R7 R8 random");
    end
    showStored("R1 R2 random end");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule